// File: doc/BRIEF.md
# Buffered Serial Byte Transmitter

This block turns bytes written by a host into asynchronous serial frames on one output line. The host writes a byte into a one-entry holding register. Whenever the serializer is free, that byte moves into a separate shift register, and the holding register becomes free again. Because the two registers are separate, the host can queue the next byte while the current frame is still on the line.

A flag tells the host when the holding register is free. An interrupt request can mirror that flag when the host enables it. Bit timing comes from `tx_tick`, a one-cycle enable pulse supplied by an external rate generator. Each frame is one low start bit, eight data bits sent least significant bit first, one even-parity bit and one high stop bit.

Top module: `sertx_buffered`

## Requirements
- R1: After reset, `tx_line` is 1 and `hold_empty` is 1.
- R2: A write (`wr_en` high at a clock edge) stores `wr_data` and clears `hold_empty`, visible in the cycle after that edge.
- R3: When a byte is pending and the serializer is idle, the byte moves to the shift register at the next clock edge and `hold_empty` returns to 1. An isolated write into an idle block therefore shows `hold_empty` low for exactly one cycle.
- R4: A frame on `tx_line` has 11 bit periods, in this order: a start bit of 0, data bits 0 to 7 (LSB first), a parity bit, and a stop bit of 1. `tx_line` changes only at edges where `tx_tick` is high, so each bit lasts one tick period.
- R5: The parity bit makes the total number of 1s across the eight data bits and the parity bit even.
- R6: While no frame is in progress, `tx_line` stays 1. A loaded frame begins its start bit at the first `tx_tick` after the load.
- R7: If the next byte is already waiting when a stop bit begins, the stop bit lasts exactly one tick period, and the next start bit is driven at the following tick.
- R8: A write while `hold_empty` is 0 replaces the pending byte, which is then never sent, and no error is raised. If a write arrives in the same cycle a transfer would happen, the write wins, and the new byte is the one sent.
- R9: `irq` is 1 exactly when `irq_en` is 1 and `hold_empty` is 1.
- R10: While a frame is being shifted, a newly written byte waits in the holding register, and `hold_empty` stays 0 until the serializer goes idle at the start of the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_tick | input | 1 | One-cycle bit-rate enable; each frame bit lasts one tick period |
| irq_en | input | 1 | Enables the interrupt request while the holding register is free |
| tx_line | output | 1 | Serial output line, 1 when idle |
| hold_empty | output | 1 | Holding register can accept a byte |
| irq | output | 1 | Interrupt request: `irq_en` AND `hold_empty` |

## Verification
`hold_empty` falls one cycle after the write edge. If the serializer is idle, it rises again one cycle after that. The bench samples it at the falling edges that follow those two clock edges.

`tx_line` changes only at a clock edge where `tx_tick` is high. The monitor therefore reads the line at the falling edge right after each tick edge, rebuilds every frame from the start bit, and compares it with the byte the write task queued. The write task replaces the queue tail when `hold_empty` shows a byte is still pending.

The stop-to-start gap is measured in ticks to confirm back-to-back framing. `irq` is combinational, so it is checked in the same half-cycle as `hold_empty`.

// File: rtl/sertx_pkg.sv
// Package: shared types for the buffered serial transmitter.
// Assumes: frames carry one start bit, DATA_W data bits, one parity bit, one stop bit.
package sertx_pkg;

    // Serializer phases: free, loaded and waiting for a tick, shifting bits.
    typedef enum logic [1:0] {
        SX_IDLE  = 2'd0,
        SX_ARMED = 2'd1,
        SX_SEND  = 2'd2
    } sx_state_t;

    // Bits that follow the start bit: data, parity and stop.
    function automatic int unsigned tail_bits(input int unsigned data_w);
        return data_w + 2;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
// Module: sertx_hold
// One-entry holding register with its free flag.
// Assumes: a host write has priority over a transfer in the same cycle;
// 'take' is only raised while the flag is clear.
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_q,
    output logic              empty_q
);

    // Capture the host byte on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q <= wr_data;
        end
    end

    // Free flag: a write clears it, a transfer to the shifter sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
        end else if (wr_en) begin
            empty_q <= 1'b0;
        end else if (take) begin
            empty_q <= 1'b1;
        end
    end

endmodule

// File: rtl/sertx_shift.sv
// Module: sertx_shift
// Frame serializer: loads a byte with its even parity, waits for a tick,
// then sends start, data (LSB first), parity and stop, one bit per tick.
// Assumes: 'load' only while 'idle' is high; 'tick' is a one-cycle enable.
// It returns to idle when the stop bit starts, so a queued byte can follow
// with a stop bit of exactly one tick period.
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              idle,
    output logic              line
);

    localparam int FW    = tail_bits(DATA_W);
    localparam int CNT_W = $clog2(FW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FW - 1);

    sx_state_t      state;
    logic [FW-1:0]  shreg;
    logic [CNT_W-1:0] cnt;
    logic           par;

    // Even parity over the byte being loaded.
    always_comb begin
        par = ^load_data;
    end

    // Phase, shift register, bit counter and line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SX_IDLE;
            shreg <= '1;
            cnt   <= '0;
            line  <= 1'b1;
        end else begin
            case (state)
                SX_IDLE: begin
                    if (load) begin
                        shreg <= {1'b1, par, load_data};
                        state <= SX_ARMED;
                    end
                end
                SX_ARMED: begin
                    if (tick) begin
                        line  <= 1'b0;
                        cnt   <= '0;
                        state <= SX_SEND;
                    end
                end
                SX_SEND: begin
                    if (tick) begin
                        line  <= shreg[0];
                        shreg <= {1'b1, shreg[FW-1:1]};
                        if (cnt == LAST) begin
                            state <= SX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= SX_IDLE;
            endcase
        end
    end

    // The serializer can take a byte only in the idle phase.
    always_comb begin
        idle = (state == SX_IDLE);
    end

endmodule

// File: rtl/sertx_buffered.sv
// Module: sertx_buffered (top)
// Double-buffered serial transmitter: a holding register feeds a frame
// serializer. It exposes a free flag and a maskable interrupt request.
// Assumes: tx_tick is a one-cycle enable from an external rate generator.
module sertx_buffered #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_tick,
    input  logic              irq_en,
    output logic              tx_line,
    output logic              hold_empty,
    output logic              irq
);

    logic [DATA_W-1:0] hold_q;
    logic              ser_idle;
    logic              take;

    // Transfer a pending byte to a free serializer unless a write is landing.
    always_comb begin
        take = ser_idle && !hold_empty && !wr_en;
    end

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .hold_q  (hold_q),
        .empty_q (hold_empty)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tx_tick),
        .load      (take),
        .load_data (hold_q),
        .idle      (ser_idle),
        .line      (tx_line)
    );

    // Interrupt request mirrors the free flag when enabled.
    always_comb begin
        irq = irq_en && hold_empty;
    end

endmodule

// File: rtl/sertx_buffered_chk.sv
// Module: sertx_buffered_chk
// Checker for sertx_buffered, bound to every instance of it.
// Assumes: synchronous active-low reset; ser_idle is the serializer phase.
module sertx_buffered_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic tx_tick,
    input logic irq_en,
    input logic tx_line,
    input logic hold_empty,
    input logic irq,
    input logic ser_idle
);

    // R2: a write leaves the holding register occupied in the next cycle.
    p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

    // R3: a pending byte with a free serializer and no write is taken.
    p_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && ser_idle && !wr_en) |=> hold_empty);

    // R4: the line moves only at tick edges.
    p_line_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_tick |=> $stable(tx_line));

    // R6: an idle serializer holds the line high.
    p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_idle |-> tx_line);

    // R10: a busy serializer keeps a pending byte waiting.
    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && !ser_idle) |=> !hold_empty);

    // R9: masked requests stay low, enabled requests follow the free flag.
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    p_irq_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && hold_empty) |-> irq);

endmodule

bind sertx_buffered sertx_buffered_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .tx_tick    (tx_tick),
    .irq_en     (irq_en),
    .tx_line    (tx_line),
    .hold_empty (hold_empty),
    .irq        (irq),
    .ser_idle   (ser_idle)
);

// File: tb/sim_sertx_buffered.sv
`timescale 1ns/1ps
// Bench for sertx_buffered: the write task queues expected bytes, and the
// monitor rebuilds frames at each tick and compares them with the queue.
module sim_sertx_buffered;

    localparam int TICK_DIV = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_tick = 1'b0;
    logic       irq_en = 1'b0;
    logic       tx_line;
    logic       hold_empty;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] expq[$];
    int tick_no = 0;
    int last_stop = -100;
    int min_gap = 1000;
    int frames = 0;
    bit in_frame = 0;
    int bitpos = 0;
    logic [9:0] got;

    sertx_buffered u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tx_tick    (tx_tick),
        .irq_en     (irq_en),
        .tx_line    (tx_line),
        .hold_empty (hold_empty),
        .irq        (irq)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Tick generator: one-cycle pulse every TICK_DIV cycles, driven off-edge.
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            tx_tick = 1'b1;
            @(negedge clk);
            tx_tick = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: queue the expected byte, replacing a still-pending one (R8).
    task automatic put_byte(input logic [7:0] b);
        if (!hold_empty && expq.size() > 0) expq[expq.size()-1] = b;
        else expq.push_back(b);
        wr_data = b;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0 || in_frame) @(negedge clk);
        repeat (3 * TICK_DIV) @(negedge clk);
    endtask

    task automatic wait_free();
        while (!hold_empty) @(negedge clk);
    endtask

    // Monitor: one line sample per tick edge, read at the following falling edge.
    always begin
        @(posedge clk);
        if (tx_tick && rst_n) begin
            @(negedge clk);
            tick_no++;
            if (!in_frame) begin
                if (tx_line == 1'b0) begin
                    in_frame = 1;
                    bitpos = 0;
                    if (tick_no - last_stop < min_gap) min_gap = tick_no - last_stop;
                end
            end else begin
                got[bitpos] = tx_line;
                bitpos++;
                if (bitpos == 10) begin
                    in_frame = 0;
                    last_stop = tick_no;
                    frames++;
                    if (expq.size() == 0) begin
                        check(0, "R4 unexpected frame", int'(got[7:0]), 0);
                    end else begin
                        logic [7:0] e;
                        e = expq.pop_front();
                        check(got[7:0] == e, "R4 data", int'(got[7:0]), int'(e));
                        check(got[8] == ^e, "R5 parity", int'(got[8]), int'(^e));
                        check(got[9] == 1'b1, "R4 stop", int'(got[9]), 1);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(tx_line == 1'b1, "R1 line", int'(tx_line), 1);
        check(hold_empty == 1'b1, "R1 empty", int'(hold_empty), 1);
        // R9: masked interrupt.
        check(irq == 1'b0, "R9 masked", int'(irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(irq == 1'b1, "R9 enabled", int'(irq), 1);

        // R6: line stays high with no data across several ticks.
        repeat (6 * TICK_DIV) @(negedge clk);
        check(tx_line == 1'b1 && frames == 0, "R6 idle", int'(tx_line), 1);

        // R2 / R3: isolated write into an idle block.
        put_byte(8'hA5);
        check(hold_empty == 1'b0, "R2 cleared", int'(hold_empty), 0);
        check(irq == 1'b0, "R9 busy", int'(irq), 0);
        @(negedge clk);
        check(hold_empty == 1'b1, "R3 refilled", int'(hold_empty), 1);
        drain();

        // R5: parity across several patterns.
        put_byte(8'h00); drain();
        put_byte(8'hFF); drain();
        put_byte(8'h01); drain();
        put_byte(8'h7F); drain();
        put_byte(8'h80); drain();

        // R10 / R8: write during a frame waits, a second write overwrites it.
        f0 = frames;
        put_byte(8'h3C);
        repeat (2) @(negedge clk);
        put_byte(8'h11);
        repeat (4 * TICK_DIV) @(negedge clk);
        check(hold_empty == 1'b0, "R10 held", int'(hold_empty), 0);
        put_byte(8'hC6);
        drain();
        check(frames - f0 == 2, "R8 overwrite count", frames - f0, 2);

        // R7: back-to-back frames have a one-tick stop bit.
        min_gap = 1000;
        put_byte(8'h55);
        wait_free();
        put_byte(8'h96);
        wait_free();
        put_byte(8'h0F);
        drain();
        check(min_gap == 1, "R7 gap", min_gap, 1);
        check(expq.size() == 0, "R4 all sent", expq.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule